// File: doc/BRIEF.md
# Pipelined Bus Transaction Queue Tracker

This block follows the transactions that are in flight on a split-phase processor bus. Requests and responses overlap on such a bus, and responses come back strictly in request order. Each accepted request-phase strobe writes one entry at the tail of an in-order queue. The entry records whether the transaction targets the local downstream bus. Each response-phase strobe retires the entry at the head. The queue holds either one entry or the full maximum. That choice is taken from a configuration pin while reset is held, and it stays fixed until the next reset.

Apart from the bus-wide depth, a second counter tracks how many accepted and not yet retired transactions target the local downstream bus. This count has its own, smaller cap. When the count sits at the cap, the request interface back-pressures any offered request that targets the local bus. Requests bound elsewhere still go through. The request side is a valid/ready pair. A request counts as taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` depends only on `req_local` and the tracker's state, never on `req_valid`, so the requester may hold an offer and wait. Queue fullness does not back-pressure the request side, because the bus itself must respect the advertised depth. A request taken while the queue is full is a protocol violation and is flagged. The response side is a plain strobe.

Top module: `txn_queue_tracker`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the queue is empty: `q_empty`=1, `q_full`=0, `head_local`=0, `err_proto`=0, and `req_ready`=1 for both values of `req_local`.
- R2: `cfg_deep` is sampled on each clock edge where `rst` is high. The value 1 selects a depth of 8 entries and the value 0 selects a depth of 1 entry. Changes on `cfg_deep` after reset have no effect on depth.
- R3: A taken request (`req_valid`=1 and `req_ready`=1) while `q_full`=0 appends one entry at the tail, with its local flag taken from `req_local`. `q_empty` reads 0 from the next cycle.
- R4: `head_local` shows the local flag of the oldest entry and reads 0 when the queue is empty. A `rsp_valid` pulse while the queue is not empty removes exactly that oldest entry.
- R5: `q_full` is 1 exactly when the number of entries equals the selected depth.
- R6: The local count is the number of entries whose local flag is 1. When it equals 4, `req_ready` is 0 while `req_local`=1 and 1 while `req_local`=0. Below 4, `req_ready` is 1.
- R7: A taken request while `q_full`=1 adds no entry and sets `err_proto` from the next cycle.
- R8: A `rsp_valid` pulse while `q_empty`=1 changes no entry and sets `err_proto` from the next cycle.
- R9: `err_proto` stays 1 until reset once it is set.
- R10: A taken request and a response in the same cycle, with the queue neither full nor empty, retire the head and append the new entry together, so the entry count is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_deep | input | 1 | Depth selection sampled during reset: 1 gives 8 entries, 0 gives 1 entry |
| req_valid | input | 1 | Request-phase strobe offered |
| req_local | input | 1 | Offered request targets the local downstream bus |
| req_ready | output | 1 | Request may be taken this cycle |
| rsp_valid | input | 1 | Response-phase strobe, retires the head entry |
| q_full | output | 1 | Queue holds the selected number of entries |
| q_empty | output | 1 | Queue holds no entry |
| head_local | output | 1 | Oldest entry targets the local bus |
| err_proto | output | 1 | Sticky overflow/underflow flag |

## Verification
On every cycle, the assertions check the following: the entry count stays within the selected depth, the local count never goes past its cap, the mode stays fixed after reset, the error flag is sticky and follows an underflow, and the single-entry mode reports full whenever it is not empty. Three things can be shown only by the bench's reference model, running scenarios over many cycles: strict request-order retirement of the local flags, the local stall releasing exactly when a local head retires, and the error cases leaving the queue contents untouched.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic {
    DEPTH_ONE = 1'b0,
    DEPTH_MAX = 1'b1
  } txq_depth_e;
endpackage

// File: rtl/txq_ring.sv
module txq_ring #(
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic                         push_local,
  input  logic                         pop,
  input  logic [$clog2(DEPTH+1)-1:0]   limit,
  output logic                         full,
  output logic                         empty,
  output logic                         head_local
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DEPTH-1:0] flag_q;
  logic [PW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;

  // one register per slot; only the addressed slot takes the new flag
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                            flag_q[i] <= 1'b0;
      else if (push && wr_q == PW'(i))    flag_q[i] <= push_local;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign empty      = (cnt_q == '0);
  assign full       = (cnt_q >= limit);
  assign head_local = !empty && flag_q[rd_q];

  AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (rst) push |-> !full); // R7
  AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (rst) pop |-> !empty); // R8
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst) cnt_q <= limit); // R5
endmodule

// File: rtl/txq_local_cnt.sv
module txq_local_cnt #(
  parameter int CAP = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic dec,
  output logic at_cap
);
  localparam int LW = $clog2(CAP + 1);

  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else begin
      case ({inc, dec})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign at_cap = (cnt_q == LW'(CAP));

  AST_LOCAL_BOUND: assert property (@(posedge clk) disable iff (rst) cnt_q <= LW'(CAP)); // R6
  AST_NO_INC_AT_CAP: assert property (@(posedge clk) disable iff (rst) inc |-> !at_cap); // R6
  AST_NO_DEC_AT_ZERO: assert property (@(posedge clk) disable iff (rst) dec |-> cnt_q != '0); // R6
endmodule

// File: rtl/txn_queue_tracker.sv
module txn_queue_tracker
  import txq_pkg::*;
#(
  parameter int MAX_DEPTH = 8,
  parameter int LOCAL_CAP = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_deep,
  input  logic req_valid,
  input  logic req_local,
  output logic req_ready,
  input  logic rsp_valid,
  output logic q_full,
  output logic q_empty,
  output logic head_local,
  output logic err_proto
);
  localparam int CW = $clog2(MAX_DEPTH + 1);

  txq_depth_e    mode_q;
  logic [CW-1:0] limit;
  logic          at_cap;
  logic          req_take, push, pop, overflow, underflow;
  logic          err_q;

  // depth mode is loaded only while reset is held
  always_ff @(posedge clk) begin
    if (rst) mode_q <= cfg_deep ? DEPTH_MAX : DEPTH_ONE;
  end

  assign limit = (mode_q == DEPTH_MAX) ? CW'(MAX_DEPTH) : CW'(1);

  assign req_ready = !(req_local && at_cap);
  assign req_take  = req_valid && req_ready;
  assign push      = req_take && !q_full;
  assign overflow  = req_take && q_full;
  assign pop       = rsp_valid && !q_empty;
  assign underflow = rsp_valid && q_empty;

  always_ff @(posedge clk) begin
    if (rst)                         err_q <= 1'b0;
    else if (overflow || underflow)  err_q <= 1'b1;
  end
  assign err_proto = err_q;

  txq_ring #(.DEPTH(MAX_DEPTH)) u_ring (
    .clk        (clk),
    .rst        (rst),
    .push       (push),
    .push_local (req_local),
    .pop        (pop),
    .limit      (limit),
    .full       (q_full),
    .empty      (q_empty),
    .head_local (head_local)
  );

  txq_local_cnt #(.CAP(LOCAL_CAP)) u_local (
    .clk    (clk),
    .rst    (rst),
    .inc    (push && req_local),
    .dec    (pop && head_local),
    .at_cap (at_cap)
  );

  AST_MODE_FIXED: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> $stable(mode_q)); // R2
  AST_SINGLE_FULL: assert property (@(posedge clk) disable iff (rst) (mode_q == DEPTH_ONE && !q_empty) |-> q_full); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) err_proto |=> err_proto); // R9
  AST_UNDERFLOW_FLAG: assert property (@(posedge clk) disable iff (rst) (rsp_valid && q_empty) |=> err_proto); // R8
  AST_PUSH_NONEMPTY: assert property (@(posedge clk) disable iff (rst) push |=> !q_empty); // R3
endmodule

// File: tb/tb_txn_queue_tracker.sv
module tb_txn_queue_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int CAP = 4;

  logic clk = 1'b0;
  logic rst, cfg_deep, req_valid, req_local, rsp_valid;
  logic req_ready, q_full, q_empty, head_local, err_proto;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  bit mq[$];
  int lcnt;
  bit merr;
  int mdepth;

  always #(CLK_PERIOD/2) clk = ~clk;

  txn_queue_tracker dut (
    .clk(clk), .rst(rst), .cfg_deep(cfg_deep),
    .req_valid(req_valid), .req_local(req_local), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .q_full(q_full), .q_empty(q_empty),
    .head_local(head_local), .err_proto(err_proto)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_outs();
    bit eh;
    eh = (mq.size() > 0) ? mq[0] : 1'b0;
    check(q_empty == (mq.size() == 0), "R3 q_empty", q_empty, mq.size() == 0);
    check(q_full == (mq.size() >= mdepth), "R5 q_full", q_full, mq.size() >= mdepth);
    check(head_local == eh, "R4 head_local", head_local, eh);
    check(err_proto == merr, "R9 err_proto", err_proto, merr);
  endtask

  // drive one cycle, check ready, update model at the edge, check registered outputs
  task automatic step(input bit v, input bit l, input bit r, input string tag);
    bit exp_rdy, take, pop, dopush;
    req_valid = v; req_local = l; rsp_valid = r;
    #1;
    exp_rdy = !(l && lcnt == CAP);
    check(req_ready == exp_rdy, {tag, " R6 req_ready"}, req_ready, exp_rdy);
    take   = v && exp_rdy;
    pop    = r && mq.size() > 0;
    dopush = take && mq.size() < mdepth;
    if (r && mq.size() == 0)       merr = 1'b1;
    if (take && mq.size() >= mdepth) merr = 1'b1;
    @(posedge clk);
    if (pop) begin
      if (mq[0]) lcnt--;
      void'(mq.pop_front());
    end
    if (dopush) begin
      mq.push_back(l);
      if (l) lcnt++;
    end
    @(negedge clk);
    req_valid = 1'b0; rsp_valid = 1'b0;
    check_outs();
  endtask

  task automatic do_reset(input bit deep);
    rst = 1'b1; cfg_deep = deep;
    req_valid = 1'b0; req_local = 1'b0; rsp_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(q_empty == 1'b1, "R1 empty in reset", q_empty, 1);
    rst = 1'b0;
    mq.delete(); lcnt = 0; merr = 1'b0; mdepth = deep ? 8 : 1;
    @(negedge clk);
    check_outs();
    req_local = 1'b1; #1;
    check(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    req_local = 1'b0;
    cfg_deep = !deep; // R2: must be ignored from here on
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // basic order and mixed flags, deep mode
    do_reset(1'b1);
    step(1, 1, 0, "R3 push local");
    step(1, 0, 0, "R3 push remote");
    step(1, 1, 0, "R3 push local");
    step(1, 0, 1, "R10 push+pop");
    check(head_local == 1'b0, "R4 head after retire", head_local, 0);
    step(0, 0, 1, "R4 pop");
    step(0, 0, 1, "R4 pop");
    step(0, 0, 1, "R4 pop last");
    check(q_empty == 1'b1, "R4 drained", q_empty, 1);

    // local cap and fill to full, then overflow
    for (int i = 0; i < 4; i++) step(1, 1, 0, "R6 fill local");
    step(1, 1, 0, "R6 local stalled");
    step(1, 0, 0, "R6 remote passes");
    for (int i = 0; i < 3; i++) step(1, 0, 0, "R5 fill remote");
    check(q_full == 1'b1, "R5 full at eight", q_full, 1);
    check(err_proto == 1'b0, "R7 no error yet", err_proto, 0);
    step(1, 0, 0, "R7 overflow");
    check(err_proto == 1'b1, "R7 overflow flagged", err_proto, 1);
    step(0, 0, 1, "R6 retire local head");
    step(1, 1, 0, "R6 local released");
    for (int i = 0; i < 10; i++) step(0, 0, 1, "R8 drain past empty");
    check(err_proto == 1'b1, "R9 sticky", err_proto, 1);

    // underflow alone
    do_reset(1'b1);
    step(0, 0, 1, "R8 underflow");
    check(err_proto == 1'b1, "R8 underflow flagged", err_proto, 1);
    step(1, 0, 0, "R9 still set");

    // single-entry mode, cfg_deep toggled to 1 after reset
    do_reset(1'b0);
    step(1, 1, 0, "R2 single push");
    check(q_full == 1'b1, "R2 depth one full", q_full, 1);
    step(1, 0, 0, "R7 single overflow");
    step(0, 0, 1, "R2 single pop");
    step(1, 0, 1, "R8 push with pop on empty");

    // random traffic in deep mode
    do_reset(1'b1);
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 55, $urandom_range(0, 1) == 1, $urandom_range(0, 99) < 45, "R10 random");
    end
    do_reset(1'b0);
    for (int i = 0; i < 200; i++)
      step($urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, "R2 random single");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule